// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Stall Unit

This block resolves data hazards for a five-stage 32-bit pipeline with eight architectural registers. It decodes the source register specifiers of the instruction in the execute stage. For each ALU operand it picks one of three sources: the register-file value, the ALU result held in the EX/MEM register, or the value held in the MEM/WB register. The surrounding datapath applies these selects to its operand multiplexers. The ALU, the register file and branch resolution sit outside this block.

The block also watches the instruction waiting in IF/ID. It raises a stall when that instruction reads a register that a load in ID/EX has not yet produced. For one cycle it then holds the PC and the IF/ID register and sends an all-zero NOP into ID/EX. Because the hardware inserts this bubble, the assembler does not need to pad the code.

A two-state machine bounds the stall to one cycle. The states are `ST_RUN`, the normal issue state, and `ST_BUBBLE`, the cycle right after a bubble was injected. The machine has two transitions. `ST_RUN -> ST_BUBBLE` is taken when a load-use hazard is seen. `ST_BUBBLE -> ST_RUN` is always taken on the next clock edge. Reset forces `ST_RUN`.

Top module: `fwd_stall_unit`

## Requirements
- R1: Source specifiers are decoded from fixed fields of an instruction word. The first source is bits 27:25 and the second source is bits 24:22. This applies to both the execute-stage word and the IF/ID word. No other bits affect the decode.
- R2: Each operand select is 2 bits wide, with the encoding 00 = register file, 01 = MEM/WB, 10 = EX/MEM. The value 11 never appears. A select is 10 when the EX/MEM destination equals that operand's source and the EX/MEM write enable is high.
- R3: A select is 01 when the MEM/WB destination equals the source, the MEM/WB write enable is high, and the EX/MEM stage does not match under R2.
- R4: When both later stages match the same source with their write enables high, the select is 10. The EX/MEM stage wins.
- R5: A stage whose write enable is low never causes forwarding from that stage, even when its destination matches.
- R6: Register 0 is never forwarded: a source of 0 always gives select 00. A load whose destination is register 0 never raises a stall.
- R7: A stall is raised in `ST_RUN` when all of the following hold: the ID/EX memory-read flag is high, its destination is nonzero, and that destination equals either source of the IF/ID word. While the stall is raised, `pc_hold`, `ifid_hold` and `nop_insert` are all 1 in the same cycle.
- R8: A stall lasts exactly one cycle. In the cycle after a stall (`ST_BUBBLE`), no stall is raised whatever the inputs are. In the cycle after that, a stall is raised again if the hazard still holds.
- R9: During a stall, the word passed on to ID/EX is all zeros, and its write-enable, memory-read and memory-write controls are 0. Otherwise the IF/ID word and the decoded controls pass through unchanged.
- R10: When the ID/EX memory-read flag is low, no stall is raised, even if the destination matches.
- R11: Reset returns the state machine to `ST_RUN`. A hazard seen in the first cycle after reset therefore stalls, even if reset arrived during `ST_BUBBLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_instr | input | 32 | Instruction word currently in ID/EX (execute stage) |
| ifid_instr | input | 32 | Instruction word currently in IF/ID |
| id_wr_en | input | 1 | Decoded register-write enable of the IF/ID instruction |
| id_mem_rd | input | 1 | Decoded memory-read flag of the IF/ID instruction |
| id_mem_wr | input | 1 | Decoded memory-write flag of the IF/ID instruction |
| idex_dst | input | 3 | Destination register of the ID/EX instruction |
| idex_mem_rd | input | 1 | ID/EX instruction is a load |
| exmem_dst | input | 3 | Destination register held in EX/MEM |
| exmem_wr_en | input | 1 | EX/MEM register-write enable |
| memwb_dst | input | 3 | Destination register held in MEM/WB |
| memwb_wr_en | input | 1 | MEM/WB register-write enable |
| fwd_a_sel | output | 2 | Select for the first ALU operand |
| fwd_b_sel | output | 2 | Select for the second ALU operand |
| pc_hold | output | 1 | Hold the PC instead of advancing by 1 |
| ifid_hold | output | 1 | Hold the IF/ID register |
| nop_insert | output | 1 | A NOP bubble is being issued into ID/EX |
| idex_instr_next | output | 32 | Instruction word to load into ID/EX |
| idex_wr_en_next | output | 1 | Register-write enable to load into ID/EX |
| idex_mem_rd_next | output | 1 | Memory-read flag to load into ID/EX |
| idex_mem_wr_next | output | 1 | Memory-write flag to load into ID/EX |

## Verification
The forwarding selects and the pass-through word are combinational, so they are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples 5 ns later, before the next rising edge. The stall outputs also appear in the cycle of the hazard. Their history takes effect one rising edge later. The bench's own model therefore records whether a stall was expected, and only after sampling, so that the following cycle is checked for suppression. Directed back-to-back dependent sequences, a held hazard, and reset during the bubble cycle are mixed with seeded random traffic.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    localparam int INSTR_W  = 32;
    localparam int REG_BITS = 3;
    localparam int SRC_A_LSB = 25;
    localparam int SRC_B_LSB = 22;
    localparam int NUM_OPS  = 2;

    typedef enum logic [1:0] {
        SEL_RF = 2'b00,
        SEL_WB = 2'b01,
        SEL_EX = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_BUBBLE = 1'b1
    } stall_state_e;
endpackage

// File: rtl/hzd_operand_fwd.sv
module hzd_operand_fwd
    import hzd_pkg::*;
#(
    parameter int RB = REG_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RB-1:0] src_i,
    input  logic [RB-1:0] exmem_dst_i,
    input  logic          exmem_we_i,
    input  logic [RB-1:0] memwb_dst_i,
    input  logic          memwb_we_i,
    output fwd_sel_e      sel_o
);
    logic src_live;
    logic ex_hit;
    logic wb_hit;

    always_comb begin
        src_live = (src_i != '0);
        ex_hit   = src_live && exmem_we_i && (exmem_dst_i == src_i);
        wb_hit   = src_live && memwb_we_i && (memwb_dst_i == src_i);
        if (ex_hit)      sel_o = SEL_EX;
        else if (wb_hit) sel_o = SEL_WB;
        else             sel_o = SEL_RF;
    end

    assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o != 2'b11);

    assert_zero_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |-> (sel_o == SEL_RF));

    assert_ex_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_we_i && memwb_we_i && src_i != '0 &&
         exmem_dst_i == src_i && memwb_dst_i == src_i) |-> (sel_o == SEL_EX));

    assert_we_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!exmem_we_i && !memwb_we_i) |-> (sel_o == SEL_RF));
endmodule

// File: rtl/hzd_loaduse_fsm.sv
module hzd_loaduse_fsm
    import hzd_pkg::*;
#(
    parameter int RB = REG_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [RB-1:0] ld_dst_i,
    input  logic [RB-1:0] use_a_i,
    input  logic [RB-1:0] use_b_i,
    output logic          stall_o
);
    stall_state_e state_q;
    stall_state_e state_d;
    logic         hazard;

    always_comb begin
        hazard = ld_i && (ld_dst_i != '0) &&
                 ((ld_dst_i == use_a_i) || (ld_dst_i == use_b_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (hazard) state_d = ST_BUBBLE;
            ST_BUBBLE: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        stall_o = 1'b0;
        unique case (state_q)
            ST_RUN:    stall_o = hazard;
            ST_BUBBLE: stall_o = 1'b0;
            default:   stall_o = 1'b0;
        endcase
    end

    assert_single_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);

    assert_no_load_no_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |-> !stall_o);

    assert_zero_dst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_dst_i == '0) |-> !stall_o);
endmodule

// File: rtl/hzd_bubble_mux.sv
module hzd_bubble_mux
    import hzd_pkg::*;
#(
    parameter int IW = INSTR_W
) (
    input  logic          bubble_i,
    input  logic [IW-1:0] instr_i,
    input  logic          we_i,
    input  logic          mrd_i,
    input  logic          mwr_i,
    output logic [IW-1:0] instr_o,
    output logic          we_o,
    output logic          mrd_o,
    output logic          mwr_o
);
    always_comb begin
        if (bubble_i) begin
            instr_o = '0;
            we_o    = 1'b0;
            mrd_o   = 1'b0;
            mwr_o   = 1'b0;
        end else begin
            instr_o = instr_i;
            we_o    = we_i;
            mrd_o   = mrd_i;
            mwr_o   = mwr_i;
        end
    end
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
    import hzd_pkg::*;
#(
    parameter int IW = INSTR_W,
    parameter int RB = REG_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ex_instr,
    input  logic [IW-1:0] ifid_instr,
    input  logic          id_wr_en,
    input  logic          id_mem_rd,
    input  logic          id_mem_wr,
    input  logic [RB-1:0] idex_dst,
    input  logic          idex_mem_rd,
    input  logic [RB-1:0] exmem_dst,
    input  logic          exmem_wr_en,
    input  logic [RB-1:0] memwb_dst,
    input  logic          memwb_wr_en,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          nop_insert,
    output logic [IW-1:0] idex_instr_next,
    output logic          idex_wr_en_next,
    output logic          idex_mem_rd_next,
    output logic          idex_mem_wr_next
);
    localparam int A_LSB = SRC_A_LSB;
    localparam int B_LSB = SRC_B_LSB;

    logic [RB-1:0] ex_src [NUM_OPS];
    logic [RB-1:0] id_src [NUM_OPS];
    fwd_sel_e      op_sel [NUM_OPS];
    logic          stall;

    always_comb begin
        ex_src[0] = ex_instr[A_LSB +: RB];
        ex_src[1] = ex_instr[B_LSB +: RB];
        id_src[0] = ifid_instr[A_LSB +: RB];
        id_src[1] = ifid_instr[B_LSB +: RB];
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hzd_operand_fwd #(.RB(RB)) u_fwd (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_i       (ex_src[g]),
            .exmem_dst_i (exmem_dst),
            .exmem_we_i  (exmem_wr_en),
            .memwb_dst_i (memwb_dst),
            .memwb_we_i  (memwb_wr_en),
            .sel_o       (op_sel[g])
        );
    end

    assign fwd_a_sel = op_sel[0];
    assign fwd_b_sel = op_sel[1];

    hzd_loaduse_fsm #(.RB(RB)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (idex_mem_rd),
        .ld_dst_i (idex_dst),
        .use_a_i  (id_src[0]),
        .use_b_i  (id_src[1]),
        .stall_o  (stall)
    );

    assign pc_hold    = stall;
    assign ifid_hold  = stall;
    assign nop_insert = stall;

    hzd_bubble_mux #(.IW(IW)) u_bub (
        .bubble_i (stall),
        .instr_i  (ifid_instr),
        .we_i     (id_wr_en),
        .mrd_i    (id_mem_rd),
        .mwr_i    (id_mem_wr),
        .instr_o  (idex_instr_next),
        .we_o     (idex_wr_en_next),
        .mrd_o    (idex_mem_rd_next),
        .mwr_o    (idex_mem_wr_next)
    );

    assert_bubble_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nop_insert |-> (idex_instr_next == '0 && !idex_wr_en_next &&
                        !idex_mem_rd_next && !idex_mem_wr_next));

    assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !nop_insert |-> (idex_instr_next == ifid_instr));

    assert_hold_with_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> (idex_instr_next == '0));
endmodule

// File: tb/fwd_stall_unit_bench.sv
module fwd_stall_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ex_instr, ifid_instr;
    logic        id_wr_en, id_mem_rd, id_mem_wr;
    logic [2:0]  idex_dst, exmem_dst, memwb_dst;
    logic        idex_mem_rd, exmem_wr_en, memwb_wr_en;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic        pc_hold, ifid_hold, nop_insert;
    logic [31:0] idex_instr_next;
    logic        idex_wr_en_next, idex_mem_rd_next, idex_mem_wr_next;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  prev_stall = 1'b0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    fwd_stall_unit u_fwd_stall_unit (
        .clk(clk), .rst_n(rst_n), .ex_instr(ex_instr), .ifid_instr(ifid_instr),
        .id_wr_en(id_wr_en), .id_mem_rd(id_mem_rd), .id_mem_wr(id_mem_wr),
        .idex_dst(idex_dst), .idex_mem_rd(idex_mem_rd),
        .exmem_dst(exmem_dst), .exmem_wr_en(exmem_wr_en),
        .memwb_dst(memwb_dst), .memwb_wr_en(memwb_wr_en),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .nop_insert(nop_insert),
        .idex_instr_next(idex_instr_next), .idex_wr_en_next(idex_wr_en_next),
        .idex_mem_rd_next(idex_mem_rd_next), .idex_mem_wr_next(idex_mem_wr_next)
    );

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [2:0] a,
                                       input logic [2:0] b, input logic [2:0] d,
                                       input logic [18:0] low);
        return {op, a, b, d, low};
    endfunction

    function automatic logic [1:0] exp_sel(input logic [2:0] src);
        if (src == 3'd0) return 2'b00;
        if (exmem_wr_en && exmem_dst == src) return 2'b10;
        if (memwb_wr_en && memwb_dst == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic bit exp_hazard();
        logic [2:0] ua = ifid_instr[27:25];
        logic [2:0] ub = ifid_instr[24:22];
        return idex_mem_rd && idex_dst != 3'd0 && (idex_dst == ua || idex_dst == ub);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        bit st;
        st = !prev_stall && exp_hazard();
        chk({tag, " R2/R3 fwd_a"}, {30'd0, fwd_a_sel}, {30'd0, exp_sel(ex_instr[27:25])});
        chk({tag, " R1 fwd_b"},   {30'd0, fwd_b_sel}, {30'd0, exp_sel(ex_instr[24:22])});
        chk({tag, " R7 stall"},   {29'd0, pc_hold, ifid_hold, nop_insert}, {29'd0, st, st, st});
        chk({tag, " R9 word"},    idex_instr_next, st ? 32'd0 : ifid_instr);
        chk({tag, " R9 ctl"},     {29'd0, idex_wr_en_next, idex_mem_rd_next, idex_mem_wr_next},
            st ? 32'd0 : {29'd0, id_wr_en, id_mem_rd, id_mem_wr});
        prev_stall = st;
    endtask

    task automatic step(input string tag);
        #5;
        check_all(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        ex_instr = '0; ifid_instr = '0; id_wr_en = 0; id_mem_rd = 0; id_mem_wr = 0;
        idex_dst = 0; idex_mem_rd = 0; exmem_dst = 0; exmem_wr_en = 0;
        memwb_dst = 0; memwb_wr_en = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        idle();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        step("reset R11");
        rst_n = 1;
        prev_stall = 0;

        // R2: EX/MEM forward to operand a, R1 decode ignores low bits
        ex_instr = mk(4'h1, 3'd3, 3'd4, 3'd5, 19'h7FFFF);
        exmem_dst = 3'd3; exmem_wr_en = 1;
        chk("R2 ex sel", 0, 0);
        step("R2 ex");
        // R3: MEM/WB to operand b
        memwb_dst = 3'd4; memwb_wr_en = 1;
        step("R3 wb");
        // R4: both stages match operand a
        memwb_dst = 3'd3;
        step("R4 prio");
        #5 chk("R4 prio sel", {30'd0, fwd_a_sel}, 32'd2); @(negedge clk);
        // R5: write enables low
        exmem_wr_en = 0; memwb_wr_en = 0;
        step("R5 we low");
        #5 chk("R5 no fwd", {30'd0, fwd_a_sel}, 32'd0); @(negedge clk);
        // R6: register 0 source and zero load destination
        ex_instr = mk(4'h2, 3'd0, 3'd0, 3'd1, 19'd0);
        exmem_dst = 0; exmem_wr_en = 1; memwb_dst = 0; memwb_wr_en = 1;
        ifid_instr = mk(4'h3, 3'd0, 3'd2, 3'd1, 19'd5);
        idex_mem_rd = 1; idex_dst = 3'd0;
        step("R6 zero");
        #5 chk("R6 no stall", {31'd0, pc_hold}, 32'd0); @(negedge clk);
        // R10: matching destination but not a load
        idex_mem_rd = 0; idex_dst = 3'd2;
        step("R10 no load");
        // R7/R8: held hazard -> stall, suppressed, stall again
        id_wr_en = 1; id_mem_rd = 1; id_mem_wr = 1;
        idex_mem_rd = 1;
        step("R7 stall");
        step("R8 bubble");
        step("R8 again");
        // R11: reset during bubble state
        rst_n = 0;
        #5; prev_stall = 0; check_all("R11 in reset");
        @(negedge clk);
        rst_n = 1; prev_stall = 0;
        step("R11 after");
        #5 chk("R11 stall after reset", {31'd0, nop_insert}, 32'd0); @(negedge clk);
        // back-to-back dependent sequence on operand b through both stages
        idle(); idex_mem_rd = 0;
        ex_instr = mk(4'h1, 3'd1, 3'd6, 3'd2, 19'd0);
        exmem_dst = 3'd6; exmem_wr_en = 1;
        step("R2 b2b ex");
        memwb_dst = 3'd6; memwb_wr_en = 1; exmem_dst = 3'd7;
        step("R3 b2b wb");
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            ex_instr    = $urandom;
            ifid_instr  = $urandom;
            id_wr_en    = $urandom_range(1, 0);
            id_mem_rd   = $urandom_range(1, 0);
            id_mem_wr   = $urandom_range(1, 0);
            idex_dst    = 3'($urandom_range(7, 0));
            idex_mem_rd = ($urandom_range(3, 0) != 0);
            exmem_dst   = 3'($urandom_range(7, 0));
            exmem_wr_en = $urandom_range(1, 0);
            memwb_dst   = 3'($urandom_range(7, 0));
            memwb_wr_en = $urandom_range(1, 0);
            if ($urandom_range(1, 0) == 1) ifid_instr[27:25] = idex_dst;
            if ($urandom_range(1, 0) == 1) ex_instr[27:25] = exmem_dst;
            if ($urandom_range(1, 0) == 1) ex_instr[24:22] = memwb_dst;
            step("rand");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule